// File: doc/BRIEF.md
# Elastic-Buffered Time-Slot Frame Assembler

This block builds one outgoing serial aggregate frame from several inputs that do not share a clock. Each of eight group ports delivers serial data on its own recovered clock into a private elastic store, 16 bits deep. A slot walker on the local master clock steps through a 64-entry slot table, one slot per master cycle. Each table entry names a source. In that slot the walker strobes one bit out of the named source onto a shared transmit bus, and the bus is registered as the NRZ serial output.

Besides the group stores, two auxiliary sources share the bus, such as an orderwire and a status channel. Each gets its own strobe, and its bit is sampled in the strobed slot. A slot whose index names no source sends a fill bit of 1. Each elastic store watches its fill level as seen from the master clock domain. A read from an empty store, or a store that has grown nearly full, is a slip. The store then recentres its read pointer to half full and sets a sticky slip flag for that port.

Top module: `fa_frame_assembler`

## Requirements
- R1: While reset is asserted and right after its release, `txd_o` is 1, `frame_sync_o` is 0 and `slip_o` is all zero. Every slot table entry resets to index 15, a fill slot.
- R2: The slot walker advances one slot per master clock and wraps from slot 63 to slot 0. `frame_sync_o` is high exactly in the cycle in which `txd_o` carries the bit of slot 0, which is once every 64 cycles.
- R3: A table write (`map_we` high at a master clock edge) stores `map_data` into entry `map_addr`. A read of that slot at the same edge still uses the old entry. Every later visit uses the new one.
- R4: Source index encoding: 0 to 7 select group ports 0 to 7, 8 selects `aux_bit[0]` and 9 selects `aux_bit[1]`. Indices 10 to 15 select no source and send a 1.
- R5: At most one strobe (group or auxiliary) is active per cycle, and only for the source of the current slot. The strobed bit appears on `txd_o` after the next master clock edge. `aux_strobe_o[a]` is high during the cycle whose closing edge samples `aux_bit[a]`.
- R6: A group store takes `grp_wbit[g]` on every rising edge of `grp_wclk[g]`. Without slips, the bits leave the store in the order they were written.
- R7: After reset each store holds 8 bits of 0. The first 8 reads of a store return 0, and the written data follow.
- R8: A strobe to a store whose fill level, as seen from the master clock domain, is zero is an underflow. That slot sends a 1, the port's slip flag sets, and the store recentres to 8 entries of fill.
- R9: When a store's fill level, as seen from the master clock domain, reaches 15 or more, the store recentres to a fill of 8 and its slip flag sets, whether or not the store is strobed.
- R10: A slip flag, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local master clock; slot walker and read side of all stores |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| grp_wclk | input | 8 | Recovered write clock, one per group port |
| grp_wbit | input | 8 | Serial data, one per group port, sampled on its write clock |
| aux_bit | input | 2 | Bits of the two auxiliary sources, sampled in their strobed slot |
| aux_strobe_o | output | 2 | Strobe to each auxiliary source for its slot |
| map_we | input | 1 | Slot table write enable |
| map_addr | input | 6 | Slot table entry to write |
| map_data | input | 4 | Source index to store |
| txd_o | output | 1 | Registered NRZ aggregate output |
| frame_sync_o | output | 1 | High while `txd_o` carries slot 0 |
| slip_o | output | 8 | Sticky slip flag per group port |

## Verification
The assertions assume that reset is released in step with the master clock and that each write clock is clean. They also assume no port's write clock runs so fast that the store wraps past its read pointer before the synchronised pointer shows the overflow. The stimulus pulses a port's write clock only once per master cycle. When it keeps a port in balance, it writes exactly one bit for each read of that port, so the slip-free order checks see a stable fill level. The overflow case runs the write clock at master rate with no reads, which reaches the recentring threshold within a few cycles. Table writes are driven away from the clock edge, and the auxiliary bits are held constant over each run.

// File: rtl/fa_pkg.sv
package fa_pkg;
    parameter int N_GRP     = 8;
    parameter int N_AUX     = 2;
    parameter int N_SLOTS   = 64;
    parameter int BUF_DEPTH = 16;
    parameter int SRC_W     = 4;
    localparam int SLOT_W   = $clog2(N_SLOTS);
endpackage

// File: rtl/fa_elastic_store.sv
module fa_elastic_store #(
    parameter int DEPTH = 16
) (
    input  logic rst_n,
    input  logic wr_clk,
    input  logic wr_bit,
    input  logic clk,
    input  logic rd_strobe,
    output logic rd_bit,
    output logic slip
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PW   = AW + 1;
    localparam int HALF = DEPTH / 2;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    typedef struct packed {
        logic [DEPTH-1:0] mem;
        logic [PW-1:0]    wptr;
        logic [PW-1:0]    wgray;
    } wr_st_t;

    typedef struct packed {
        logic [PW-1:0] sync1;
        logic [PW-1:0] sync2;
        logic [PW-1:0] rptr;
        logic          slip;
    } rd_st_t;

    wr_st_t wr_d, wr_q;
    rd_st_t rd_d, rd_q;

    // write domain
    always_comb begin
        wr_d = wr_q;
        wr_d.mem[wr_q.wptr[AW-1:0]] = wr_bit;
        wr_d.wptr  = wr_q.wptr + PW'(1);
        wr_d.wgray = to_gray(wr_d.wptr);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    // read domain
    logic [PW-1:0] wbin;
    logic [PW-1:0] fill;
    logic          empty_read;
    logic          near_full;

    always_comb begin
        wbin       = from_gray(rd_q.sync2);
        fill       = wbin - rd_q.rptr;
        empty_read = rd_strobe && (fill == '0);
        near_full  = (fill >= PW'(DEPTH - 1));
        rd_bit     = empty_read ? 1'b1 : wr_q.mem[rd_q.rptr[AW-1:0]];

        rd_d       = rd_q;
        rd_d.sync1 = wr_q.wgray;
        rd_d.sync2 = rd_q.sync1;
        if (empty_read || near_full) begin
            rd_d.rptr = wbin - PW'(HALF);
            rd_d.slip = 1'b1;
        end else if (rd_strobe) begin
            rd_d.rptr = rd_q.rptr + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= '0;
            rd_q.rptr <= PW'(0) - PW'(HALF);
        end else begin
            rd_q <= rd_d;
        end
    end

    assign slip = rd_q.slip;

    AST_SLIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q.slip |=> rd_q.slip); // R10
    AST_EMPTY_READ_SLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (fill == '0)) |=> rd_q.slip); // R8
    AST_FULL_SLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill >= PW'(DEPTH - 1)) |=> rd_q.slip); // R9
endmodule

// File: rtl/fa_slot_sequencer.sv
module fa_slot_sequencer
    import fa_pkg::*;
#(
    parameter int SLOTS = N_SLOTS,
    parameter int SW    = SRC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       map_we,
    input  logic [$clog2(SLOTS)-1:0]   map_addr,
    input  logic [SW-1:0]              map_data,
    output logic [SW-1:0]              sel_o,
    output logic                       first_o
);
    localparam int AW = $clog2(SLOTS);

    typedef struct packed {
        logic [AW-1:0]            slot;
        logic [SLOTS-1:0][SW-1:0] map;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slot = (st_q.slot == AW'(SLOTS - 1)) ? '0 : st_q.slot + AW'(1);
        if (map_we) st_d.map[map_addr] = map_data;
        sel_o   = st_q.map[st_q.slot];
        first_o = (st_q.slot == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= '0;
            st_q.map  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot == AW'(SLOTS - 1)) |=> (st_q.slot == '0)); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.slot != AW'(SLOTS - 1)) |=> (st_q.slot == $past(st_q.slot) + AW'(1))); // R2
    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> (st_q.map[$past(map_addr)] == $past(map_data))); // R3
endmodule

// File: rtl/fa_frame_assembler.sv
module fa_frame_assembler
    import fa_pkg::*;
#(
    parameter int NG    = N_GRP,
    parameter int NA    = N_AUX,
    parameter int SLOTS = N_SLOTS,
    parameter int DEPTH = BUF_DEPTH,
    parameter int SW    = SRC_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NG-1:0]              grp_wclk,
    input  logic [NG-1:0]              grp_wbit,
    input  logic [NA-1:0]              aux_bit,
    output logic [NA-1:0]              aux_strobe_o,
    input  logic                       map_we,
    input  logic [$clog2(SLOTS)-1:0]   map_addr,
    input  logic [SW-1:0]              map_data,
    output logic                       txd_o,
    output logic                       frame_sync_o,
    output logic [NG-1:0]              slip_o
);
    typedef struct packed {
        logic txd;
        logic frame;
    } out_st_t;

    logic [SW-1:0] sel;
    logic          first;
    logic [NG-1:0] grp_strobe;
    logic [NG-1:0] grp_rbit;
    logic          bus_bit;
    out_st_t       out_d, out_q;

    fa_slot_sequencer #(.SLOTS(SLOTS), .SW(SW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_we   (map_we),
        .map_addr (map_addr),
        .map_data (map_data),
        .sel_o    (sel),
        .first_o  (first)
    );

    for (genvar g = 0; g < NG; g++) begin : g_store
        assign grp_strobe[g] = (sel == SW'(g));
        fa_elastic_store #(.DEPTH(DEPTH)) store_i (
            .rst_n     (rst_n),
            .wr_clk    (grp_wclk[g]),
            .wr_bit    (grp_wbit[g]),
            .clk       (clk),
            .rd_strobe (grp_strobe[g]),
            .rd_bit    (grp_rbit[g]),
            .slip      (slip_o[g])
        );
    end

    for (genvar a = 0; a < NA; a++) begin : g_aux
        assign aux_strobe_o[a] = (sel == SW'(NG + a));
    end

    // shared transmit bus: idle level is the fill bit
    always_comb begin
        bus_bit = 1'b1;
        for (int g = 0; g < NG; g++) if (grp_strobe[g]) bus_bit = grp_rbit[g];
        for (int a = 0; a < NA; a++) if (aux_strobe_o[a]) bus_bit = aux_bit[a];
        out_d.txd   = bus_bit;
        out_d.frame = first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.txd   <= 1'b1;
            out_q.frame <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign txd_o        = out_q.txd;
    assign frame_sync_o = out_q.frame;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({aux_strobe_o, grp_strobe})); // R5
    AST_FILL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(|{aux_strobe_o, grp_strobe}) |=> txd_o); // R4
    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync_o |=> !frame_sync_o); // R2
endmodule

// File: tb/fa_frame_assembler_tb_top.sv
module fa_frame_assembler_tb_top;
    localparam int NG = 8;
    localparam int NS = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG-1:0] grp_wclk = '0;
    logic [NG-1:0] grp_wbit = '0;
    logic [1:0]    aux_bit = '0;
    logic [1:0]    aux_strobe_o;
    logic          map_we = 1'b0;
    logic [5:0]    map_addr = '0;
    logic [3:0]    map_data = '0;
    logic          txd_o, frame_sync_o;
    logic [NG-1:0] slip_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    int            bmap [NS];
    int            slot_ctr;
    int            rd_cnt [NG];
    int            fillm [NG];
    int            wj [NG];
    bit            wr_on [NG];
    logic [NG-1:0] exp_slip;

    always #10 clk = ~clk;

    fa_frame_assembler dut_i (
        .clk(clk), .rst_n(rst_n), .grp_wclk(grp_wclk), .grp_wbit(grp_wbit),
        .aux_bit(aux_bit), .aux_strobe_o(aux_strobe_o), .map_we(map_we),
        .map_addr(map_addr), .map_data(map_data), .txd_o(txd_o),
        .frame_sync_o(frame_sync_o), .slip_o(slip_o)
    );

    function automatic bit pat(int i);
        return ((i * 13 + (i >> 2)) % 3) == 1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        map_we = 1'b0;
        grp_wclk = '0;
        grp_wbit = '0;
        for (int s = 0; s < NS; s++) bmap[s] = 15;
        for (int g = 0; g < NG; g++) begin
            rd_cnt[g] = 0; fillm[g] = 8; wj[g] = 0; wr_on[g] = 0;
        end
        exp_slip = '0;
        slot_ctr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one master cycle, called at a negedge; checks the bit of the current slot
    task automatic step(bit we, int addr, int data);
        int  slot, src;
        bit  eb;
        logic [1:0] es;
        slot = slot_ctr;
        src  = bmap[slot];
        es   = (src == 8) ? 2'b01 : (src == 9) ? 2'b10 : 2'b00;
        chk("R5 aux strobe", aux_strobe_o, es);
        if (src < NG) begin
            if (wr_on[src]) begin
                eb = (rd_cnt[src] < 8) ? 1'b0 : pat(rd_cnt[src] - 8);
                rd_cnt[src]++;
            end else if (fillm[src] == 0) begin
                eb = 1'b1; exp_slip[src] = 1'b1; fillm[src] = 8;
            end else begin
                eb = 1'b0; fillm[src]--;
            end
        end else if (src < 10) begin
            eb = aux_bit[src-8];
        end else begin
            eb = 1'b1;
        end
        map_we = we;
        map_addr = 6'(addr);
        map_data = 4'(data);
        if (we) bmap[addr] = data;
        @(posedge clk);
        slot_ctr = (slot_ctr + 1) % NS;
        if (src < NG && wr_on[src]) begin
            grp_wbit[src] = pat(wj[src]);
            wj[src]++;
            #4 grp_wclk[src] = 1'b1;
            #4 grp_wclk[src] = 1'b0;
        end
        @(negedge clk);
        map_we = 1'b0;
        chk("R2 frame sync", frame_sync_o, (slot == 0));
        chk("R4/R6/R7/R8 txd bit", txd_o, eb);
        chk("R8/R10 slip flags", slip_o, exp_slip);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 txd during reset", txd_o, 1'b1);
        chk("R1 frame during reset", frame_sync_o, 1'b0);
        chk("R1 slip during reset", slip_o, '0);
        do_reset();
        chk("R1 txd after release", txd_o, 1'b1);
        chk("R1 slip after release", slip_o, '0);
        // R1 R4: reset table is all fill slots
        repeat (NS + 2) step(0, 0, 0);
    endtask

    task automatic t_aux_map();
        do_reset();
        aux_bit = 2'b10;
        // R3: program while the walker runs
        for (int s = 0; s < NS; s++) begin
            int d;
            d = (s % 2 == 1) ? 9 : 8;
            if (s == 5) d = 12;
            if (s == 6) d = 15;
            step(1, (s + 20) % NS, d);
        end
        repeat (NS) step(0, 0, 0);
        aux_bit = 2'b01;
        repeat (NS) step(0, 0, 0);
        // R3: rewrite one entry while running
        step(1, 7, 10);
        repeat (NS + 3) step(0, 0, 0);
    endtask

    task automatic t_stream();
        do_reset();
        wr_on[0] = 1;
        for (int s = 0; s < NS; s++) step(1, s, (s == 3) ? 8 : 0);
        repeat (2 * NS) step(0, 0, 0);
        chk("R6 no slip in balanced stream", slip_o[0], 1'b0);
    endtask

    task automatic t_underflow();
        do_reset();
        for (int s = 0; s < NS; s++) step(1, s, 2);
        repeat (NS) step(0, 0, 0);
        chk("R8 underflow flagged", slip_o[2], 1'b1);
        chk("R10 other ports clear", slip_o & 8'hFB, 8'h00);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            #5 grp_wclk[1] = 1'b1;
            #5 grp_wclk[1] = 1'b0;
            if (i == 3) begin
                @(negedge clk);
                chk("R9 no early slip", slip_o, 8'h00);
            end
        end
        @(negedge clk);
        chk("R9 overflow flagged", slip_o, 8'h02);
        chk("R4 fill while unmapped", txd_o, 1'b1);
        repeat (10) @(negedge clk);
        chk("R10 slip held", slip_o, 8'h02);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_aux_map();
        t_stream();
        t_underflow();
        t_overflow();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule